// File: doc/BRIEF.md
# Dual-Bus Register File

This block holds a bank of general-purpose data registers that sit between two shared bidirectional data buses, called A and B. Each bus has its own port: a register select, an active-low load strobe and an active-low drive strobe. Through one port a register can be written from its bus, or read back onto that bus. Both ports work at the same time and are independent of each other. In one cycle, for example, one register can be written from A while another is read onto B.

The block is synchronous to `clk`. The strobes are sampled on the rising clock edge. A load strobe takes a value and a select while it is low, and the write happens when the strobe returns high. The read path is combinational. While a drive strobe is low, its bus carries the selected register. While it is high, the block releases that bus to high impedance so that other agents can use it. The block arbitrates nothing: the surrounding controller keeps agents from driving a bus at the same time.

Top module: `dual_bus_regfile`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every register holds 0x0000.
- R2: While a port's drive strobe is 0, its bus carries the current contents of the register its select names. The bus follows changes of the select and of the register within the same cycle.
- R3: While a port's drive strobe is 1, the block does not drive that port's bus. A value placed on the bus by another agent reads back unchanged.
- R4: A write through a port takes the select and the bus value from the last clock edge at which the load strobe was sampled 0. The write happens at the first following edge at which the strobe is sampled 1, and the new value is visible from then on.
- R5: The A and B ports work together. Both can write different registers at the same release edge. Both can read, each its own register, in the same cycle. Either port on its own can write any register.
- R6: When both ports write the same register at the same edge, the value from port A is stored and the value from port B is dropped.
- R7: While a load strobe is still held at 0, the targeted register keeps its previous value, as seen through the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | SEL_W (4) | Register number used by port A |
| load_a_n | input | 1 | Port A load strobe, 0 = capture from bus A |
| drive_a_n | input | 1 | Port A drive strobe, 0 = put register on bus A |
| bus_a | inout | DATA_W (16) | Shared bidirectional bus A |
| sel_b | input | SEL_W (4) | Register number used by port B |
| load_b_n | input | 1 | Port B load strobe, 0 = capture from bus B |
| drive_b_n | input | 1 | Port B drive strobe, 0 = put register on bus B |
| bus_b | inout | DATA_W (16) | Shared bidirectional bus B |

## Verification
The bench builds the block with its default sizes: sixteen registers of sixteen bits and a four-bit select. This makes it practical to write and read every register, including the highest index, through both ports, with patterns that set bits across the whole word. While its strobe is idle, the bench holds each bus at zero itself, so any stray drive from the block shows up as a nonzero value. Every write pattern is nonzero, so such a drive can always be seen.

// File: rtl/dbrf_pkg.sv
package dbrf_pkg;

  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_NUM_REGS = 16;

  // Width of a register select for a bank of n entries.
  function automatic int unsigned sel_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dbrf_load_port.sv
// Captures select and bus data while the load strobe is low; presents a
// one-cycle commit once the strobe is sampled high again.
module dbrf_load_port #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] bus_in,
  output logic              commit,
  output logic [SEL_W-1:0]  commit_idx,
  output logic [DATA_W-1:0] commit_data
);

  logic              armed_q;
  logic [SEL_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else if (!load_n) begin
      armed_q <= 1'b1;
      idx_q   <= sel;
      data_q  <= bus_in;
    end else begin
      armed_q <= 1'b0;
    end
  end

  assign commit      = armed_q && load_n;
  assign commit_idx  = idx_q;
  assign commit_data = data_q;

endmodule

// File: rtl/dbrf_storage.sv
// Register array with two write ports; port A takes precedence per entry.
module dbrf_storage #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SEL_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             a_commit,
  input  logic [SEL_W-1:0]                 a_idx,
  input  logic [DATA_W-1:0]                a_data,
  input  logic                             b_commit,
  input  logic [SEL_W-1:0]                 b_idx,
  input  logic [DATA_W-1:0]                b_data,
  output logic [NUM_REGS-1:0]              we_a,
  output logic [NUM_REGS-1:0]              we_b,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    assign we_a[i] = a_commit && (a_idx == SEL_W'(i));
    assign we_b[i] = b_commit && (b_idx == SEL_W'(i)) && !we_a[i];

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (we_a[i])
        regs_q[i] <= a_data;
      else if (we_b[i])
        regs_q[i] <= b_data;
    end
  end

endmodule

// File: rtl/dbrf_drive_port.sv
// Read mux and output enable for one bus.
module dbrf_drive_port #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SEL_W    = 4
) (
  input  logic                             drive_n,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic                             oe,
  output logic [DATA_W-1:0]                dout
);

  always_comb begin
    dout = '0;
    if (32'(sel) < NUM_REGS)
      dout = regs[sel];
  end

  assign oe = !drive_n;

endmodule

// File: rtl/dual_bus_regfile.sv
module dual_bus_regfile #(
  parameter  int unsigned DATA_W   = dbrf_pkg::DEF_DATA_W,
  parameter  int unsigned NUM_REGS = dbrf_pkg::DEF_NUM_REGS,
  localparam int unsigned SEL_W    = dbrf_pkg::sel_width(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic              load_a_n,
  input  logic              drive_a_n,
  inout  wire  [DATA_W-1:0] bus_a,
  input  logic [SEL_W-1:0]  sel_b,
  input  logic              load_b_n,
  input  logic              drive_b_n,
  inout  wire  [DATA_W-1:0] bus_b
);

  logic                            a_commit, b_commit;
  logic [SEL_W-1:0]                a_cidx, b_cidx;
  logic [DATA_W-1:0]               a_cdata, b_cdata;
  logic [NUM_REGS-1:0]             we_a, we_b;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic                            a_oe, b_oe;
  logic [DATA_W-1:0]               a_dout, b_dout;

  dbrf_load_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_load_a (
    .clk(clk), .rst_n(rst_n), .load_n(load_a_n), .sel(sel_a), .bus_in(bus_a),
    .commit(a_commit), .commit_idx(a_cidx), .commit_data(a_cdata)
  );

  dbrf_load_port #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_load_b (
    .clk(clk), .rst_n(rst_n), .load_n(load_b_n), .sel(sel_b), .bus_in(bus_b),
    .commit(b_commit), .commit_idx(b_cidx), .commit_data(b_cdata)
  );

  dbrf_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_commit(a_commit), .a_idx(a_cidx), .a_data(a_cdata),
    .b_commit(b_commit), .b_idx(b_cidx), .b_data(b_cdata),
    .we_a(we_a), .we_b(we_b), .regs_q(regs_q)
  );

  dbrf_drive_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_drv_a (
    .drive_n(drive_a_n), .sel(sel_a), .regs(regs_q), .oe(a_oe), .dout(a_dout)
  );

  dbrf_drive_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_drv_b (
    .drive_n(drive_b_n), .sel(sel_b), .regs(regs_q), .oe(b_oe), .dout(b_dout)
  );

  assign bus_a = a_oe ? a_dout : 'z;
  assign bus_b = b_oe ? b_dout : 'z;

endmodule

// File: rtl/dbrf_checker.sv
module dbrf_checker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SEL_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SEL_W-1:0]    sel_a,
  input logic [SEL_W-1:0]    sel_b,
  input logic                load_a_n,
  input logic                load_b_n,
  input logic                drive_a_n,
  input logic                drive_b_n,
  input logic [DATA_W-1:0]   bus_a,
  input logic [DATA_W-1:0]   bus_b,
  input logic                a_commit,
  input logic                b_commit,
  input logic [SEL_W-1:0]    a_cidx,
  input logic [SEL_W-1:0]    b_cidx,
  input logic                a_oe,
  input logic                b_oe,
  input logic [NUM_REGS-1:0] we_a,
  input logic [NUM_REGS-1:0] we_b
);

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n)
      age_q <= '0;
    else if (age_q != 2'd3)
      age_q <= age_q + 2'd1;
  end

  assert_idle_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_a_n |-> !a_oe);
  assert_idle_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_b_n |-> !b_oe);

  assert_release_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && load_a_n && !$past(load_a_n)) |-> a_commit);
  assert_release_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0 && load_b_n && !$past(load_b_n)) |-> b_commit);
  assert_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_a_n |-> !a_commit) and (!load_b_n |-> !b_commit));

  assert_a_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_commit && b_commit && a_cidx == b_cidx) |-> (we_b == '0));

  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_a) && $onehot0(we_b) && ((we_a & we_b) == '0));

  assert_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !drive_b_n && !$past(drive_b_n) && $stable(sel_b)
     && $past(load_a_n, 2) && $past(load_b_n, 2)) |-> $stable(bus_b));
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !drive_a_n && !$past(drive_a_n) && $stable(sel_a)
     && $past(load_a_n, 2) && $past(load_b_n, 2)) |-> $stable(bus_a));

endmodule

bind dual_bus_regfile dbrf_checker #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
  .load_a_n(load_a_n), .load_b_n(load_b_n),
  .drive_a_n(drive_a_n), .drive_b_n(drive_b_n),
  .bus_a(bus_a), .bus_b(bus_b),
  .a_commit(a_commit), .b_commit(b_commit),
  .a_cidx(a_cidx), .b_cidx(b_cidx),
  .a_oe(a_oe), .b_oe(b_oe), .we_a(we_a), .we_b(we_b)
);

// File: tb/tb_dual_bus_regfile.sv
module tb_dual_bus_regfile;

  localparam int W = 16;
  localparam int N = 16;
  localparam int SW = 4;
  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] sel_a = '0, sel_b = '0;
  logic ld_a_n = 1'b1, ld_b_n = 1'b1, dr_a_n = 1'b1, dr_b_n = 1'b1;
  logic [W-1:0] tv_a = '0, tv_b = '0;
  wire  [W-1:0] bus_a, bus_b;

  // Bench side of the shared buses: drives whenever the block is not asked to.
  assign bus_a = dr_a_n ? tv_a : 'z;
  assign bus_b = dr_b_n ? tv_b : 'z;

  always #(HALF) clk = ~clk;

  dual_bus_regfile #(.DATA_W(W), .NUM_REGS(N)) dut (
    .clk(clk), .rst_n(rst_n),
    .sel_a(sel_a), .load_a_n(ld_a_n), .drive_a_n(dr_a_n), .bus_a(bus_a),
    .sel_b(sel_b), .load_b_n(ld_b_n), .drive_b_n(dr_b_n), .bus_b(bus_b)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i + 1) * 16'h1111) ^ 16'h0F00;
  endfunction

  // Behavioural reference: contents plus pending write per port.
  logic [W-1:0] m [N];
  bit pa, pb, ca, cb;
  logic [SW-1:0] pai, pbi;
  logic [W-1:0] pad, pbd;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = '0;
      pa = 0; pb = 0;
    end else begin
      ca = pa && ld_a_n;
      cb = pb && ld_b_n;
      if (cb) m[pbi] = pbd;
      if (ca) m[pai] = pad;   // A applied last, so A wins (R6)
      if (!ld_a_n) begin pa = 1; pai = sel_a; pad = bus_a; end else pa = 0;
      if (!ld_b_n) begin pb = 1; pbi = sel_b; pbd = bus_b; end else pb = 0;
    end
  end

  // Every-clock comparison of both buses against the reference.
  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      if (dr_a_n) check("R3 bus A released", bus_a, tv_a);
      else        check("R2 bus A read", bus_a, m[sel_a]);
      if (dr_b_n) check("R3 bus B released", bus_b, tv_b);
      else        check("R2 bus B read", bus_b, m[sel_b]);
    end
  end

  task automatic settle;
    @(posedge clk); #6;
  endtask

  task automatic load2(input bit ena, input int ia, input logic [W-1:0] da,
                       input bit enb, input int ib, input logic [W-1:0] db);
    @(negedge clk);
    if (ena) begin sel_a = SW'(ia); tv_a = da; ld_a_n = 0; end
    if (enb) begin sel_b = SW'(ib); tv_b = db; ld_b_n = 0; end
    @(negedge clk);
    ld_a_n = 1; ld_b_n = 1; tv_a = '0; tv_b = '0;
    settle();
  endtask

  task automatic read2(input int ia, input int ib, input logic [W-1:0] ea,
                       input logic [W-1:0] eb, input string tag);
    @(negedge clk);
    sel_a = SW'(ia); sel_b = SW'(ib); dr_a_n = 0; dr_b_n = 0;
    settle();
    check({tag, " port A"}, bus_a, ea);
    check({tag, " port B"}, bus_b, eb);
    @(negedge clk);
    dr_a_n = 1; dr_b_n = 1;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: every register reads zero after reset, through both ports
    for (int i = 0; i < N; i++) read2(i, N - 1 - i, '0, '0, "R1 reset value");

    // R5: simultaneous writes of different registers, then crossed reads
    for (int i = 0; i < N / 2; i++) load2(1, i, pat(i), 1, N - 1 - i, pat(N - 1 - i));
    for (int i = 0; i < N; i++) read2(N - 1 - i, i, pat(N - 1 - i), pat(i), "R5 crossed read");

    // R7: held load leaves old contents visible through B until release
    @(negedge clk);
    sel_a = 4'd5; tv_a = 16'hBEEF; ld_a_n = 0;
    sel_b = 4'd5; dr_b_n = 0;
    settle();
    check("R7 held load, first cycle", bus_b, pat(5));
    @(negedge clk);
    settle();
    check("R7 held load, second cycle", bus_b, pat(5));
    @(negedge clk);
    ld_a_n = 1; tv_a = '0;
    settle();
    check("R4 value after release", bus_b, 16'hBEEF);
    @(negedge clk);
    dr_b_n = 1;

    // R4: select and data taken from the last low-sampled edge
    @(negedge clk);
    sel_a = 4'd2; tv_a = 16'h1234; ld_a_n = 0;
    @(negedge clk);
    sel_a = 4'd9; tv_a = 16'hC0DE;
    @(negedge clk);
    ld_a_n = 1; tv_a = '0;
    settle();
    read2(2, 9, pat(2), 16'hC0DE, "R4 last sample wins");

    // R6: both ports hit register 7 at the same release edge
    load2(1, 7, 16'hAAAA, 1, 7, 16'h5555);
    read2(7, 7, 16'hAAAA, 16'hAAAA, "R6 A priority");
    // R5: B alone writes the same register, highest index via B too
    load2(0, 0, '0, 1, 7, 16'h5555);
    load2(0, 0, '0, 1, 15, 16'h7E7E);
    read2(7, 15, 16'h5555, 16'h7E7E, "R5 B-only write");

    // R2: bus follows the select while the drive strobe stays low
    @(negedge clk);
    dr_a_n = 0; dr_b_n = 0; sel_a = '0; sel_b = SW'(N - 1);
    for (int k = 0; k < N; k++) begin
      settle();
      check("R2 sweep port A", bus_a, m[k]);
      check("R2 sweep port B", bus_b, m[N - 1 - k]);
      @(negedge clk);
      sel_a = SW'(k + 1); sel_b = SW'(N - 2 - k);
    end
    dr_a_n = 1; dr_b_n = 1;

    // R3: with strobes idle the bench's own value stays on both buses
    @(negedge clk);
    sel_a = 4'd3; sel_b = 4'd4; tv_a = 16'h0000; tv_b = 16'h0000;
    settle();
    check("R3 idle bus A", bus_a, 16'h0000);
    check("R3 idle bus B", bus_b, 16'h0000);

    // R1: reset in mid-run clears the bank again
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < N; i++) read2(i, N - 1 - i, '0, '0, "R1 reset again");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule